// File: doc/BRIEF.md
# Two-Stage Switch Allocator with Arbiter Bypass

This block decides, every cycle, which flits in a five-port router cross the crossbar. Each input port has four virtual channels. A first stage picks one candidate channel per input port. A second stage settles the case where several input ports want the same output. Both stages use round-robin arbiters, so no channel or port is starved. The grants are combinational from the request inputs and the arbiter pointers. The pointers move at the clock edge.

Faults are reported to the block by external flags; the block does not detect them. A flagged first-stage arbiter is replaced by a fixed path that always selects that port's default channel. The default channel number is taken from an input while reset is held. The port then refills an empty default channel from the other channels of the same port. It moves whole packets, one flit per cycle. A flagged second-stage arbiter leaves its output without a primary arbiter. The arbiter of the next output (in wrapping order) then serves those requests in cycles when it has none of its own, and the grant is marked as using the secondary crossbar path.

Top module: `sw_alloc`

## Requirements
- R1: The first stage picks, per input port, the requesting channel found first when counting up from the port's pointer with wrap. The pointer reset value is 0. The pointer moves to one past the picked channel only in a cycle where that port receives a final grant.
- R2: The second stage grants each output to at most one input port. It picks the requesting port found first when counting up from the output arbiter's pointer with wrap. The pointer reset value is 0. The pointer moves to one past the granted port whenever that arbiter grants.
- R3: `vc_gnt_o` bit p*4+v is set when channel v of port p wins both stages. For each output o, `xb_vld_o[o]` flags a grant and `xb_sel_o[o*3+:3]` holds the granted input port number. The select field is 0 when the output has no grant.
- R4: While `sa1_fault_i[p]` is set, only the default channel of port p can be granted. It is picked whenever it requests, whatever the other channels of that port do.
- R5: Each port's default channel is loaded from `dflt_vc_i[p*2+:2]` on clock edges while `rst_n` is low. Changes to that input after reset have no effect.
- R6: With `sa1_fault_i[p]` set, port p's default channel empty, and no move in progress, the port moves one flit per cycle into the default channel. The flit comes from the lowest-numbered non-empty other channel. The move is shown by `mig_move_o[p]`, and `mig_src_o[p*2+:2]` gives the source channel.
- R7: Once a move starts, the same source channel is kept until a flit with `tail_i` set is moved. While that source is empty no move happens and no other channel is chosen.
- R8: No move starts on a port whose fault flag is clear, or whose default channel is not empty. When no move happens, `mig_src_o` for that port is 0.
- R9: While `sa2_fault_i[o]` is set, requests for output o are served by the arbiter of output (o+1) mod 5. That arbiter serves them only in cycles when it has no request of its own. Such a grant sets `xb_alt_o[o]`.
- R10: If the arbiters of output o and of output (o+1) mod 5 are both flagged faulty, output o receives no grant.
- R11: While `rst_n` is low all grant, crossbar and move outputs are 0, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 20 | Bit p*4+v: channel v of port p has a flit ready |
| dest_i | input | 60 | Field (p*4+v)*3: output port requested by that channel |
| tail_i | input | 20 | Head flit of that channel is a tail flit |
| vc_empty_i | input | 20 | That channel holds no flit |
| dflt_vc_i | input | 10 | Per-port default channel number, sampled in reset |
| sa1_fault_i | input | 5 | Per-port first-stage arbiter fault flag |
| sa2_fault_i | input | 5 | Per-output second-stage arbiter fault flag |
| vc_gnt_o | output | 20 | Final per-channel grant |
| xb_vld_o | output | 5 | Output has a granted input |
| xb_sel_o | output | 15 | Per-output granted input port number |
| xb_alt_o | output | 5 | Grant uses the secondary crossbar path |
| mig_move_o | output | 5 | Per-port flit move into the default channel this cycle |
| mig_src_o | output | 10 | Per-port source channel of the move |

## Verification
The hardest situation to reach is a refill of the default channel that stops partway through a packet. The source channel runs dry while another channel on the same port still holds flits, and the mover must neither switch channels nor finish early. The stimulus drives this directly through the empty and tail inputs: it empties the source mid-packet, refills it, and then raises the tail flag. A second hard case is the borrowed output arbiter. Its service depends on whether the neighbour output has its own traffic in the same cycle, so that case is set up as paired vectors that differ only in that neighbour request.

// File: rtl/sw_alloc_pkg.sv
package sw_alloc_pkg;

  // Index of the first set bit met when counting up from ptr with wrap, -1 if none.
  function automatic int rr_pick(logic [31:0] req, int ptr, int n);
    int idx;
    rr_pick = -1;
    for (int k = n - 1; k >= 0; k--) begin
      idx = ptr + k;
      if (idx >= n) idx = idx - n;
      if (req[idx]) rr_pick = idx;
    end
  endfunction

  // Index of the lowest set bit, 0 if none.
  function automatic int lowest_set(logic [31:0] v, int n);
    lowest_set = 0;
    for (int k = n - 1; k >= 0; k--) begin
      if (v[k]) lowest_set = k;
    end
  endfunction

endpackage

// File: rtl/sw_rr_arb.sv
module sw_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  input  logic         adv,
  output logic [N-1:0] gnt
);
  import sw_alloc_pkg::*;
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q;
  int            pick;
  logic          any_gnt;

  always_comb begin
    pick = rr_pick({{(32-N){1'b0}}, req}, int'(ptr_q), N);
    for (int k = 0; k < N; k++) gnt[k] = (pick == k);
    any_gnt = (pick >= 0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (adv && any_gnt) begin
      ptr_q <= (pick + 1 >= N) ? '0 : IW'(pick + 1);
    end
  end

  p_gnt_subset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);

endmodule

// File: rtl/sw_in_port.sv
module sw_in_port #(
  parameter int V = 4,
  parameter int P = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [V-1:0]       req,
  input  logic [V*PW-1:0]    dest,
  input  logic [V-1:0]       tail,
  input  logic [V-1:0]       empty,
  input  logic [VW-1:0]      dflt_in,
  input  logic               byp,
  input  logic               won,
  output logic               s1_vld,
  output logic [PW-1:0]      s1_dest,
  output logic [V-1:0]       vc_gnt,
  output logic               mig_move,
  output logic [VW-1:0]      mig_src
);
  import sw_alloc_pkg::*;
  localparam int VW = $clog2(V);
  localparam int PW = $clog2(P);

  logic [VW-1:0] dflt_q;
  logic [V-1:0]  dflt_oh;
  logic [V-1:0]  arb_gnt;
  logic [V-1:0]  s1_gnt;
  int            s1_i;

  // Moving state for default-channel refill
  logic          lock_q;
  logic [VW-1:0] src_q;
  logic [V-1:0]  cand;
  logic          mv;
  logic [VW-1:0] src;

  always_comb begin
    for (int k = 0; k < V; k++) dflt_oh[k] = (dflt_q == VW'(k));
  end

  sw_rr_arb #(.N(V)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req & {V{~byp}}),
    .adv   (won & ~byp),
    .gnt   (arb_gnt)
  );

  // Bypass mux: arbiter result or the fixed default channel
  always_comb begin
    s1_gnt  = byp ? (req & dflt_oh) : arb_gnt;
    s1_gnt  = s1_gnt & {V{rst_n}};
    s1_vld  = |s1_gnt;
    s1_i    = lowest_set({{(32-V){1'b0}}, s1_gnt}, V);
    s1_dest = dest[s1_i*PW +: PW];
    vc_gnt  = s1_gnt & {V{won}};
  end

  always_comb begin
    cand = ~empty & ~dflt_oh;
    mv   = 1'b0;
    src  = '0;
    if (lock_q) begin
      mv  = !empty[src_q];
      src = src_q;
    end else if (byp && empty[dflt_q] && (|cand)) begin
      mv  = 1'b1;
      src = VW'(lowest_set({{(32-V){1'b0}}, cand}, V));
    end
    mv       = mv & rst_n;
    mig_move = mv;
    mig_src  = mv ? src : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dflt_q <= dflt_in;
      lock_q <= 1'b0;
      src_q  <= '0;
    end else if (mv) begin
      if (tail[src]) begin
        lock_q <= 1'b0;
      end else begin
        lock_q <= 1'b1;
        src_q  <= src;
      end
    end
  end

  p_vc_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vc_gnt));

  p_bypass_default_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (byp && (|vc_gnt)) |-> (vc_gnt == dflt_oh));

  p_mig_not_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mig_move |-> (mig_src != dflt_q));

  p_mig_whole_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mig_move && !tail[mig_src]) |=> (!mig_move || mig_src == $past(mig_src)));

endmodule

// File: rtl/sw_out_arb.sv
module sw_out_arb #(
  parameter int P = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [P-1:0] own_req,
  input  logic [P-1:0] bor_req,
  input  logic         fault,
  output logic [P-1:0] gnt,
  output logic         alt
);
  logic [P-1:0] eff_req;

  always_comb begin
    if (fault)         eff_req = '0;
    else if (|own_req) eff_req = own_req;
    else               eff_req = bor_req;
    alt = !fault && (own_req == '0) && (bor_req != '0);
  end

  sw_rr_arb #(.N(P)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (eff_req),
    .adv   (1'b1),
    .gnt   (gnt)
  );

  p_borrow_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (alt && (|gnt)) |-> (own_req == '0));

  p_fault_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (gnt == '0));

endmodule

// File: rtl/sw_alloc.sv
module sw_alloc #(
  parameter int P = 5,
  parameter int V = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [P*V-1:0]       req_i,
  input  logic [P*V*PW-1:0]    dest_i,
  input  logic [P*V-1:0]       tail_i,
  input  logic [P*V-1:0]       vc_empty_i,
  input  logic [P*VW-1:0]      dflt_vc_i,
  input  logic [P-1:0]         sa1_fault_i,
  input  logic [P-1:0]         sa2_fault_i,
  output logic [P*V-1:0]       vc_gnt_o,
  output logic [P-1:0]         xb_vld_o,
  output logic [P*PW-1:0]      xb_sel_o,
  output logic [P-1:0]         xb_alt_o,
  output logic [P-1:0]         mig_move_o,
  output logic [P*VW-1:0]      mig_src_o
);
  import sw_alloc_pkg::*;
  localparam int VW = $clog2(V);
  localparam int PW = $clog2(P);

  logic [P-1:0]  s1_vld;
  logic [PW-1:0] s1_dest [P];
  logic [P-1:0]  won;
  logic [P-1:0]  own_req [P];
  logic [P-1:0]  bor_req [P];
  logic [P-1:0]  a_gnt   [P];
  logic [P-1:0]  a_alt;
  logic [P-1:0]  out_gnt [P];
  logic [P-1:0]  in_col  [P];

  for (genvar p = 0; p < P; p++) begin : g_in
    sw_in_port #(.V(V), .P(P)) u_in (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req_i[p*V +: V]),
      .dest     (dest_i[p*V*PW +: V*PW]),
      .tail     (tail_i[p*V +: V]),
      .empty    (vc_empty_i[p*V +: V]),
      .dflt_in  (dflt_vc_i[p*VW +: VW]),
      .byp      (sa1_fault_i[p]),
      .won      (won[p]),
      .s1_vld   (s1_vld[p]),
      .s1_dest  (s1_dest[p]),
      .vc_gnt   (vc_gnt_o[p*V +: V]),
      .mig_move (mig_move_o[p]),
      .mig_src  (mig_src_o[p*VW +: VW])
    );
  end

  // Requests seen by each output, and those lent to the next arbiter
  always_comb begin
    for (int k = 0; k < P; k++) begin
      for (int i = 0; i < P; i++) begin
        own_req[k][i] = s1_vld[i] && (s1_dest[i] == PW'(k));
      end
    end
    for (int k = 0; k < P; k++) begin
      bor_req[k] = sa2_fault_i[(k + P - 1) % P] ? own_req[(k + P - 1) % P] : '0;
    end
  end

  for (genvar k = 0; k < P; k++) begin : g_out
    sw_out_arb #(.P(P)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .own_req (own_req[k]),
      .bor_req (bor_req[k]),
      .fault   (sa2_fault_i[k]),
      .gnt     (a_gnt[k]),
      .alt     (a_alt[k])
    );
  end

  // Route primary or secondary arbiter results onto each output
  always_comb begin
    won = '0;
    for (int o = 0; o < P; o++) begin
      if (!sa2_fault_i[o]) begin
        out_gnt[o]  = a_alt[o] ? '0 : a_gnt[o];
        xb_alt_o[o] = 1'b0;
      end else begin
        out_gnt[o]  = a_alt[(o + 1) % P] ? a_gnt[(o + 1) % P] : '0;
        xb_alt_o[o] = |out_gnt[o];
      end
      xb_vld_o[o]            = |out_gnt[o];
      xb_sel_o[o*PW +: PW]   = PW'(lowest_set({{(32-P){1'b0}}, out_gnt[o]}, P));
      won                    = won | out_gnt[o];
    end
    for (int i = 0; i < P; i++) begin
      for (int o = 0; o < P; o++) in_col[i][o] = out_gnt[o][i];
    end
  end

  for (genvar o = 0; o < P; o++) begin : g_chk
    p_out_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(out_gnt[o]));
    p_in_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_col[o]));
    p_alt_needs_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
      xb_alt_o[o] |-> sa2_fault_i[o]);
    p_dead_output_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (sa2_fault_i[o] && sa2_fault_i[(o + 1) % P]) |-> !xb_vld_o[o]);
  end

endmodule

// File: tb/sw_alloc_bench.sv
module sw_alloc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] req_i = '0;
  logic [59:0] dest_i = '0;
  logic [19:0] tail_i = '0;
  logic [19:0] vc_empty_i = '1;
  logic [9:0]  dflt_vc_i = {2'd3, 2'd3, 2'd1, 2'd3, 2'd3};
  logic [4:0]  sa1_fault_i = '0;
  logic [4:0]  sa2_fault_i = '0;
  logic [19:0] vc_gnt_o;
  logic [4:0]  xb_vld_o;
  logic [14:0] xb_sel_o;
  logic [4:0]  xb_alt_o;
  logic [4:0]  mig_move_o;
  logic [9:0]  mig_src_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  sw_alloc u_sw_alloc (.*);

  // {req 20, dest nibbles 80, s1f 5, s2f 5, gnt 20, vld 5, alt 5, sel nibbles 20}
  localparam logic [159:0] TBL [10] = '{
    {20'h00000, 80'h00000000000000000000, 5'b00000, 5'b00000, 20'h00000, 5'b00000, 5'b00000, 20'h00000}, // R3 idle
    {20'h00004, 80'h00000000000000000300, 5'b00000, 5'b00000, 20'h00004, 5'b01000, 5'b00000, 20'h00000}, // R3 single
    {20'h02010, 80'h00000020000000020000, 5'b00000, 5'b00000, 20'h00010, 5'b00100, 5'b00000, 20'h00100}, // R2 conflict
    {20'h10A00, 80'h00040000400000000000, 5'b00000, 5'b00000, 20'h10200, 5'b10001, 5'b00000, 20'h40002}, // R1 R2 mix
    {20'h00009, 80'h00000000000000001001, 5'b00001, 5'b00000, 20'h00008, 5'b00010, 5'b00000, 20'h00000}, // R4 default wins
    {20'h00002, 80'h00000000000000000020, 5'b00001, 5'b00000, 20'h00000, 5'b00000, 5'b00000, 20'h00000}, // R4 others blocked
    {20'h00010, 80'h00000000000000020000, 5'b00000, 5'b00100, 20'h00010, 5'b00100, 5'b00100, 20'h00100}, // R9 borrow
    {20'h00011, 80'h00000000000000020003, 5'b00000, 5'b00100, 20'h00001, 5'b01000, 5'b00000, 20'h00000}, // R9 lender busy
    {20'h00010, 80'h00000000000000020000, 5'b00000, 5'b01100, 20'h00000, 5'b00000, 5'b00000, 20'h00000}, // R10 dead
    {20'h00100, 80'h00000000000400000000, 5'b00000, 5'b10000, 20'h00100, 5'b10000, 5'b10000, 20'h20000}  // R9 wrap
  };

  task automatic check(string tag, logic [19:0] e_gnt, logic [4:0] e_vld,
                       logic [14:0] e_sel, logic [4:0] e_alt,
                       logic [4:0] e_mv, logic [9:0] e_src);
    n_chk++;
    if (vc_gnt_o !== e_gnt || xb_vld_o !== e_vld || xb_sel_o !== e_sel ||
        xb_alt_o !== e_alt || mig_move_o !== e_mv || mig_src_o !== e_src) begin
      n_bad++;
      $display("FAIL %s gnt=%h/%h vld=%b/%b sel=%h/%h alt=%b/%b mv=%b/%b src=%h/%h",
               tag, vc_gnt_o, e_gnt, xb_vld_o, e_vld, xb_sel_o, e_sel,
               xb_alt_o, e_alt, mig_move_o, e_mv, mig_src_o, e_src);
    end
  endtask

  task automatic set_dest(logic [79:0] nib);
    for (int i = 0; i < 20; i++) dest_i[i*3 +: 3] = nib[i*4 +: 3];
  endtask

  function automatic logic [14:0] sel_of(logic [19:0] nib);
    logic [14:0] s;
    for (int o = 0; o < 5; o++) s[o*3 +: 3] = nib[o*4 +: 3];
    return s;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    req_i = '0; tail_i = '0; vc_empty_i = '1;
    sa1_fault_i = '0; sa2_fault_i = '0; dest_i = '0;
    dflt_vc_i = {2'd3, 2'd3, 2'd1, 2'd3, 2'd3};
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #2000000;
    n_bad++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    // R11: outputs held at zero in reset despite busy inputs
    #1;
    req_i = '1; vc_empty_i = 20'h00000; sa1_fault_i = 5'b00001; set_dest('0);
    repeat (2) @(posedge clk);
    #2 check("R11 reset", '0, '0, '0, '0, '0, '0);
    do_reset();

    for (int i = 0; i < 10; i++) begin
      logic [159:0] t;
      string tag;
      t = TBL[i];
      tag = (i < 2) ? "R3 table" : (i < 4) ? "R2 table" : (i < 6) ? "R4 table" :
            (i == 8) ? "R10 table" : "R9 table";
      do_reset();
      sa1_fault_i = t[59:55];
      sa2_fault_i = t[54:50];
      set_dest(t[139:60]);
      req_i = t[159:140];
      #2 check(tag, t[49:30], t[29:25], sel_of(t[19:0]), t[24:20], '0, '0);
    end

    // R1: round robin inside one port
    do_reset();
    set_dest('0);
    req_i = 20'h00007;
    #2 check("R1 rr c1", 20'h00001, 5'b00001, '0, '0, '0, '0); tick();
    check("R1 rr c2", 20'h00002, 5'b00001, '0, '0, '0, '0); tick();
    check("R1 rr c3", 20'h00004, 5'b00001, '0, '0, '0, '0); tick();
    check("R1 rr c4", 20'h00001, 5'b00001, '0, '0, '0, '0);

    // R2: round robin across ports on one output
    do_reset();
    set_dest('0);
    req_i = 20'h00111;
    #2 check("R2 rr c1", 20'h00001, 5'b00001, 15'd0, '0, '0, '0); tick();
    check("R2 rr c2", 20'h00010, 5'b00001, 15'd1, '0, '0, '0); tick();
    check("R2 rr c3", 20'h00100, 5'b00001, 15'd2, '0, '0, '0); tick();
    check("R2 rr c4", 20'h00001, 5'b00001, 15'd0, '0, '0, '0);

    // R1: losing port keeps its first-stage pointer
    do_reset();
    set_dest('0);
    req_i = 20'h00031;
    #2 check("R1 hold c1", 20'h00001, 5'b00001, 15'd0, '0, '0, '0); tick();
    check("R1 hold c2", 20'h00010, 5'b00001, 15'd1, '0, '0, '0); tick();
    check("R1 hold c3", 20'h00001, 5'b00001, 15'd0, '0, '0, '0);

    // R4 R5: bypass on port 2 whose default channel is 1
    do_reset();
    set_dest('0);
    sa1_fault_i = 5'b00100;
    req_i = 20'h00F00;
    #2 check("R4 byp c1", 20'h00200, 5'b00001, 15'd2, '0, '0, '0); tick();
    check("R4 byp c2", 20'h00200, 5'b00001, 15'd2, '0, '0, '0);
    dflt_vc_i = {2'd3, 2'd3, 2'd2, 2'd3, 2'd3};
    tick();
    check("R5 dflt after reset", 20'h00200, 5'b00001, 15'd2, '0, '0, '0);
    req_i = 20'h00D00;
    #1 check("R4 byp idle", 20'h00000, 5'b00000, 15'd0, '0, '0, '0);

    // R6 R7 R8: refill of port 0 default channel 3
    do_reset();
    sa1_fault_i = 5'b00001;
    vc_empty_i = 20'hFFFE9;
    #2 check("R6 start", '0, '0, '0, '0, 5'b00001, 10'h001); tick();
    check("R7 continue", '0, '0, '0, '0, 5'b00001, 10'h001);
    vc_empty_i = 20'hFFFEB;
    #1 check("R7 pause", '0, '0, '0, '0, 5'b00000, 10'h000); tick();
    vc_empty_i = 20'hFFFE9;
    tail_i = 20'h00002;
    #1 check("R7 tail", '0, '0, '0, '0, 5'b00001, 10'h001); tick();
    tail_i = '0;
    vc_empty_i = 20'hFFFE3;
    #1 check("R8 dflt busy", '0, '0, '0, '0, 5'b00000, 10'h000); tick();
    vc_empty_i = 20'hFFFEB;
    #1 check("R6 next pkt", '0, '0, '0, '0, 5'b00001, 10'h002);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule